// File: doc/BRIEF.md
# Reset Pin Discriminator

This block owns the active-low reset pin of a small microcontroller. The pin is shared: the board can pull it low to reset the device, and the block can pull it low itself through an open-drain style enable when a clock-monitor fault or a watchdog fault is reported. While either party holds the pin low, the block keeps the core in reset.

After its own low pulse of fixed length, the block lets go of the pin and times how long the pin takes to come back high. A quick return means nothing outside was holding the line, so the reset is kept as internal and its cause is reported as the fault that triggered it. A slow return means an outside agent is also holding the line, such as a slow power-up network or a button, so the reset is reported as external instead. All timing is counted in bus cycles. A bus cycle is `DIV` enabled input-clock cycles, and a clock enable can freeze the count.

The pin level passes through a synchronizer before any decision is made. The three cause flags stay one-hot and keep their value until the next reset event.

Top module: `rstpin_discrim`

## Requirements
- R1: While `arst_n` is low and right after it rises, `pin_drive_lo` and `core_rst` are 0 and all three cause flags are 0.
- R2: When a fault request is seen while the block is idle, `pin_drive_lo` goes high for exactly `DRIVE_E*DIV` cycles with `clk_en` high, which is 64 with the defaults. `core_rst` is high for that whole time.
- R3: `pin_in` passes through `SYNC_STAGES` flops before the sequencer uses it. A pin change made just after a clock edge reaches the sequencer at the edge `SYNC_STAGES+1` edges later.
- R4: Let k be the clock edge at which the drive is released. If the synchronized pin reads high at or before edge k+`RISE_E*DIV`, the reset stays internal. With the defaults, this means the raw pin is high before edge k+14. Otherwise the cause changes to external.
- R5: `core_rst` stays high while the block drives the pin and while the synchronized pin is low. It falls `HOLD_E*DIV` enabled cycles after the sequencer first sees the pin high. With the defaults there are 18 core-reset cycles after an external release, and 19 after a release by the block's own drive.
- R6: The cause flags are one-hot in the order {`cause_ext`, `cause_cmf`, `cause_wdt`}. If both fault requests arrive in the same cycle, the clock-monitor cause wins.
- R7: A fault request that arrives during a reset sequence is ignored. It neither restarts nor lengthens the drive, and it does not change the cause.
- R8: A low pin seen while the block is idle starts an external reset. `core_rst` goes high, the pin is not driven, and the cause is external.
- R9: While `clk_en` is low, bus-cycle counting stops. A drive pulse is lengthened by exactly the number of disabled cycles.
- R10: If the pin goes low again during the post-release hold, the sequence becomes external. `core_rst` stays high, the cause changes to external, and the hold restarts after the pin rises.
- R11: The cause flags do not change while the block is idle. They keep the result of the last sequence until a new reset event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock (four per bus cycle by default) |
| arst_n | input | 1 | Asynchronous power-on reset of the block, active low |
| clk_en | input | 1 | Bus-cycle count enable; low freezes all timing |
| pin_in | input | 1 | Raw level of the reset pin, asynchronous |
| cmf_req | input | 1 | Clock-monitor fault request |
| wdt_req | input | 1 | Watchdog fault request |
| pin_drive_lo | output | 1 | Open-drain enable; 1 pulls the reset pin low |
| core_rst | output | 1 | Reset to the core, active high |
| cause_ext | output | 1 | Last reset came from outside the block |
| cause_cmf | output | 1 | Last reset came from the clock monitor |
| cause_wdt | output | 1 | Last reset came from the watchdog |

## Verification
Two decisions can land on the same clock edge. One is the timeout of the rise window and the first high sample of the synchronized pin. The other is two fault requests arriving together, or a fault request arriving during a running sequence. The bench holds the pin low past the drive release and lets it go 13 and then 14 cycles after release, so the rise lands exactly on the timeout edge and one cycle after it. It expects internal and then external classification. It also raises both fault requests in one cycle, and raises a watchdog request in the middle of a clock-monitor pulse. A scoreboard compares each finished sequence's drive length, cause and post-release hold against values computed from the requirements.

// File: rtl/rstpin_pkg.sv
package rstpin_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_DRIVE  = 3'd1,
      ST_WATCH  = 3'd2,
      ST_EXTLOW = 3'd3,
      ST_HOLD   = 3'd4
   } rp_state_e;

   typedef struct packed {
      logic ext;
      logic cmf;
      logic wdt;
   } rp_cause_t;

   localparam rp_cause_t CAUSE_NONE = 3'b000;
   localparam rp_cause_t CAUSE_EXT  = 3'b100;
   localparam rp_cause_t CAUSE_CMF  = 3'b010;
   localparam rp_cause_t CAUSE_WDT  = 3'b001;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/rstpin_sync.sv
module rstpin_sync #(
   parameter int  STAGES    = 2,
   parameter logic RST_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);

   for (genvar i = 0; i < STAGES; i++) begin : g_st
      logic din;
      logic ff;
      if (i == 0) begin : g_first
         assign din = d;
      end else begin : g_next
         assign din = g_st[i-1].ff;
      end
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) ff <= RST_LEVEL;
         else         ff <= din;
      end
   end

   assign q = g_st[STAGES-1].ff;

endmodule

// File: rtl/rstpin_prescale.sv
module rstpin_prescale #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic arst_n,
   input  logic clk_en,
   input  logic restart,
   output logic e_tick
);

   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   logic [PW-1:0] phase;

   assign e_tick = clk_en && (phase == LAST);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)      phase <= '0;
      else if (restart) phase <= '0;
      else if (clk_en)  phase <= e_tick ? '0 : phase + 1'b1;
   end

endmodule

// File: rtl/rstpin_seq.sv
module rstpin_seq
   import rstpin_pkg::*;
#(
   parameter int DRIVE_E = 16,
   parameter int RISE_E  = 4,
   parameter int HOLD_E  = 4
) (
   input  logic      clk,
   input  logic      arst_n,
   input  logic      e_tick,
   input  logic      pin_s,
   input  logic      cmf_req,
   input  logic      wdt_req,
   output logic      phase_chg,
   output logic      drive_lo,
   output logic      core_rst,
   output rp_cause_t cause
);

   localparam int MAXE = max3(DRIVE_E, RISE_E, HOLD_E);
   localparam int EW   = $clog2(MAXE + 1);
   localparam logic [EW-1:0] DRV_LAST  = EW'(DRIVE_E - 1);
   localparam logic [EW-1:0] RISE_LAST = EW'(RISE_E - 1);
   localparam logic [EW-1:0] HOLD_LAST = EW'(HOLD_E - 1);

   rp_state_e     st, st_nxt;
   rp_cause_t     cause_nxt;
   logic [EW-1:0] ecnt;
   logic          counting;

   always_comb begin
      st_nxt    = st;
      cause_nxt = cause;
      unique case (st)
         ST_IDLE: begin
            if (cmf_req || wdt_req) begin
               st_nxt    = ST_DRIVE;
               cause_nxt = cmf_req ? CAUSE_CMF : CAUSE_WDT;
            end else if (!pin_s) begin
               st_nxt    = ST_EXTLOW;
               cause_nxt = CAUSE_EXT;
            end
         end
         ST_DRIVE: begin
            if (e_tick && ecnt == DRV_LAST) st_nxt = ST_WATCH;
         end
         ST_WATCH: begin
            if (pin_s) begin
               st_nxt = ST_HOLD;
            end else if (e_tick && ecnt == RISE_LAST) begin
               st_nxt    = ST_EXTLOW;
               cause_nxt = CAUSE_EXT;
            end
         end
         ST_EXTLOW: begin
            if (pin_s) st_nxt = ST_HOLD;
         end
         ST_HOLD: begin
            if (!pin_s) begin
               st_nxt    = ST_EXTLOW;
               cause_nxt = CAUSE_EXT;
            end else if (e_tick && ecnt == HOLD_LAST) begin
               st_nxt = ST_IDLE;
            end
         end
         default: st_nxt = ST_IDLE;
      endcase
   end

   assign phase_chg = (st_nxt != st);
   assign counting  = (st == ST_DRIVE) || (st == ST_WATCH) || (st == ST_HOLD);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         st    <= ST_IDLE;
         cause <= CAUSE_NONE;
         ecnt  <= '0;
      end else begin
         st    <= st_nxt;
         cause <= cause_nxt;
         if (phase_chg)                ecnt <= '0;
         else if (counting && e_tick)  ecnt <= ecnt + 1'b1;
      end
   end

   assign drive_lo = (st == ST_DRIVE);
   assign core_rst = (st != ST_IDLE);

endmodule

// File: rtl/rstpin_discrim.sv
module rstpin_discrim
   import rstpin_pkg::*;
#(
   parameter int DIV         = 4,
   parameter int DRIVE_E     = 16,
   parameter int RISE_E      = 4,
   parameter int HOLD_E      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic clk_en,
   input  logic pin_in,
   input  logic cmf_req,
   input  logic wdt_req,
   output logic pin_drive_lo,
   output logic core_rst,
   output logic cause_ext,
   output logic cause_cmf,
   output logic cause_wdt
);

   if (DIV < 2) begin : g_bad_div
      $error("rstpin_discrim: DIV must be at least 2");
   end
   if (DRIVE_E < 1 || RISE_E < 1 || HOLD_E < 1) begin : g_bad_len
      $error("rstpin_discrim: phase lengths must be at least one bus cycle");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("rstpin_discrim: SYNC_STAGES must be at least 2");
   end

   logic      pin_sync;
   logic      e_tick;
   logic      phase_chg;
   rp_cause_t cause;

   rstpin_sync #(
      .STAGES    (SYNC_STAGES),
      .RST_LEVEL (1'b1)
   ) u_sync (
      .clk    (clk),
      .arst_n (arst_n),
      .d      (pin_in),
      .q      (pin_sync)
   );

   rstpin_prescale #(
      .DIV (DIV)
   ) u_pre (
      .clk     (clk),
      .arst_n  (arst_n),
      .clk_en  (clk_en),
      .restart (phase_chg),
      .e_tick  (e_tick)
   );

   rstpin_seq #(
      .DRIVE_E (DRIVE_E),
      .RISE_E  (RISE_E),
      .HOLD_E  (HOLD_E)
   ) u_seq (
      .clk       (clk),
      .arst_n    (arst_n),
      .e_tick    (e_tick),
      .pin_s     (pin_sync),
      .cmf_req   (cmf_req),
      .wdt_req   (wdt_req),
      .phase_chg (phase_chg),
      .drive_lo  (pin_drive_lo),
      .core_rst  (core_rst),
      .cause     (cause)
   );

   assign cause_ext = cause.ext;
   assign cause_cmf = cause.cmf;
   assign cause_wdt = cause.wdt;

endmodule

// File: rtl/rstpin_discrim_chk.sv
module rstpin_discrim_chk (
   input logic       clk,
   input logic       arst_n,
   input logic       clk_en,
   input logic       pin_s,
   input logic       cmf_req,
   input logic       wdt_req,
   input logic       drive_lo,
   input logic       core_rst,
   input logic [2:0] cause
);

   // R6
   cause_onehot_chk: assert property (@(posedge clk) disable iff (!arst_n)
      $onehot0(cause));

   // R2
   drive_in_reset_chk: assert property (@(posedge clk) disable iff (!arst_n)
      drive_lo |-> core_rst);

   // R7
   drive_from_idle_chk: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(drive_lo) |-> $past(!core_rst));

   // R7
   cause_frozen_in_drive_chk: assert property (@(posedge clk) disable iff (!arst_n)
      drive_lo |=> (!drive_lo || $stable(cause)));

   // R5
   low_pin_resets_chk: assert property (@(posedge clk) disable iff (!arst_n)
      !pin_s |=> core_rst);

   // R8
   ext_entry_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (!core_rst && !pin_s && !cmf_req && !wdt_req) |=> (core_rst && !drive_lo && cause == 3'b100));

   // R6
   cmf_priority_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (!core_rst && cmf_req) |=> (drive_lo && cause == 3'b010));

   // R9
   frozen_drive_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (drive_lo && !clk_en) |=> drive_lo);

   // R11
   idle_cause_stable_chk: assert property (@(posedge clk) disable iff (!arst_n)
      !core_rst |=> (core_rst || $stable(cause)));

endmodule

bind rstpin_discrim rstpin_discrim_chk u_chk (
   .clk      (clk),
   .arst_n   (arst_n),
   .clk_en   (clk_en),
   .pin_s    (pin_sync),
   .cmf_req  (cmf_req),
   .wdt_req  (wdt_req),
   .drive_lo (pin_drive_lo),
   .core_rst (core_rst),
   .cause    ({cause_ext, cause_cmf, cause_wdt})
);

// File: tb/rstpin_discrim_tb.sv
`timescale 1ns/1ps
module rstpin_discrim_tb;

   localparam int DIV = 4;
   localparam int DRIVE_CYC = 16 * DIV;
   localparam int TAIL_OWN = 19;
   localparam int TAIL_EXT = 18;

   typedef struct {
      int         drv;
      logic [2:0] cause;
      int         tail;
      string      tag;
   } exp_t;

   logic clk = 1'b0;
   logic arst_n = 1'b0;
   logic clk_en = 1'b1;
   logic cmf_req = 1'b0;
   logic wdt_req = 1'b0;
   logic ext_low = 1'b0;
   logic pin_raw;
   logic pin_drive_lo, core_rst, cause_ext, cause_cmf, cause_wdt;

   int n_run = 0;
   int n_fail = 0;
   exp_t exp_q[$];
   int drv_n = 0;
   int tail_n = 0;
   logic prev_rst = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   assign pin_raw = ~(pin_drive_lo | ext_low);

   rstpin_discrim u_dut (
      .clk          (clk),
      .arst_n       (arst_n),
      .clk_en       (clk_en),
      .pin_in       (pin_raw),
      .cmf_req      (cmf_req),
      .wdt_req      (wdt_req),
      .pin_drive_lo (pin_drive_lo),
      .core_rst     (core_rst),
      .cause_ext    (cause_ext),
      .cause_cmf    (cause_cmf),
      .cause_wdt    (cause_wdt)
   );

   task automatic chk(input string tag, input int act, input int expv);
      n_run++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic push(input int drv, input logic [2:0] c, input int tail, input string tag);
      exp_t e;
      e.drv = drv; e.cause = c; e.tail = tail; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic wait_done();
      while (!core_rst) @(negedge clk);
      while (core_rst) @(negedge clk);
      step(3);
   endtask

   task automatic wait_release();
      while (!pin_drive_lo) @(negedge clk);
      while (pin_drive_lo) @(negedge clk);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (!arst_n) begin
         prev_rst = 1'b0;
      end else begin
         if (core_rst && !prev_rst) begin
            drv_n = 0;
            tail_n = 0;
         end
         if (core_rst) begin
            if (pin_drive_lo) drv_n++;
            if (pin_raw) tail_n++;
            else         tail_n = 0;
         end
         if (!core_rst && prev_rst) begin
            if (exp_q.size() == 0) begin
               chk("R2 unexpected sequence", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk({e.tag, " drive length"}, drv_n, e.drv);
               chk({e.tag, " cause"}, int'({cause_ext, cause_cmf, cause_wdt}), int'(e.cause));
               chk({e.tag, " hold after rise"}, tail_n, e.tail);
            end
         end
         prev_rst = core_rst;
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      step(2);
      chk("R1 drive in reset", int'(pin_drive_lo), 0);
      chk("R1 core_rst in reset", int'(core_rst), 0);
      arst_n = 1'b1;
      step(1);
      chk("R1 cause after reset", int'({cause_ext, cause_cmf, cause_wdt}), 0);
      chk("R1 core_rst after reset", int'(core_rst), 0);
      step(4);

      // R2 R5 watchdog, fast rise
      push(DRIVE_CYC, 3'b001, TAIL_OWN, "R2 R5 wdt");
      wdt_req = 1'b1; step(1); wdt_req = 1'b0;
      wait_done();

      // R2 clock monitor
      push(DRIVE_CYC, 3'b010, TAIL_OWN, "R2 cmf");
      cmf_req = 1'b1; step(1); cmf_req = 1'b0;
      wait_done();

      // R6 both faults in one cycle
      push(DRIVE_CYC, 3'b010, TAIL_OWN, "R6 priority");
      cmf_req = 1'b1; wdt_req = 1'b1; step(1); cmf_req = 1'b0; wdt_req = 1'b0;
      wait_done();

      // R7 fault during sequence ignored
      push(DRIVE_CYC, 3'b010, TAIL_OWN, "R7 late fault");
      cmf_req = 1'b1; step(1); cmf_req = 1'b0;
      step(10);
      wdt_req = 1'b1; step(1); wdt_req = 1'b0;
      step(2);
      chk("R7 cause mid drive", int'({cause_ext, cause_cmf, cause_wdt}), 3'b010);
      wait_done();

      // R4 R3 slow rise, release 13 cycles after drive ends: internal
      push(DRIVE_CYC, 3'b001, TAIL_EXT, "R4 R3 rise at limit");
      wdt_req = 1'b1; ext_low = 1'b1; step(1); wdt_req = 1'b0;
      wait_release();
      repeat (13) @(negedge clk);
      #1 ext_low = 1'b0;
      wait_done();

      // R4 slow rise, release 14 cycles after drive ends: external
      push(DRIVE_CYC, 3'b100, TAIL_EXT, "R4 rise too late");
      wdt_req = 1'b1; ext_low = 1'b1; step(1); wdt_req = 1'b0;
      wait_release();
      repeat (14) @(negedge clk);
      #1 ext_low = 1'b0;
      wait_done();

      // R8 external press
      push(0, 3'b100, TAIL_EXT, "R8 external");
      ext_low = 1'b1;
      step(10);
      chk("R8 core_rst held", int'(core_rst), 1);
      chk("R8 no drive", int'(pin_drive_lo), 0);
      chk("R8 cause external", int'({cause_ext, cause_cmf, cause_wdt}), 3'b100);
      step(20);
      ext_low = 1'b0;
      wait_done();

      // R9 clock enable gap during drive
      push(DRIVE_CYC + 10, 3'b010, TAIL_OWN, "R9 enable gap");
      cmf_req = 1'b1; step(1); cmf_req = 1'b0;
      step(5);
      clk_en = 1'b0;
      step(10);
      clk_en = 1'b1;
      wait_done();

      // R10 pin low again during hold
      push(DRIVE_CYC, 3'b100, TAIL_EXT, "R10 hold glitch");
      wdt_req = 1'b1; step(1); wdt_req = 1'b0;
      wait_release();
      repeat (8) @(negedge clk);
      #1 ext_low = 1'b1;
      step(5);
      chk("R10 still in reset", int'(core_rst), 1);
      ext_low = 1'b0;
      wait_done();

      // R11 cause holds in idle
      step(30);
      chk("R11 cause kept", int'({cause_ext, cause_cmf, cause_wdt}), 3'b100);
      chk("R11 idle core_rst", int'(core_rst), 0);
      chk("R2 all sequences seen", exp_q.size(), 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule